// File: doc/BRIEF.md
# Paged Register Window

This bridge lets a small outer configuration space reach a much larger internal register space. A page register in the outer space holds the upper part of an internal address. A fixed 512-byte window, also in the outer space, supplies the lower part. An outer access that hits the window is forwarded as a single 32-bit internal access. Its address is the stored page joined with the nine low bits of the outer offset.

Software first writes the page register and then reads or writes a window location. The page keeps its value until it is written again, so several accesses inside one 512-byte page need only one page write. Window writes are posted to the internal side in the cycle they are presented. Window reads hold the outer side off with `cfg_ready` until the internal read data returns.

The outer protocol works like this. The master raises `cfg_req` with `cfg_we`, `cfg_addr` and `cfg_wdata`, and holds them until `cfg_ready` is high. The transfer completes at the rising clock edge where both are high. The internal side takes a request in the cycle `int_req` is high. It returns read data later with a one-cycle `int_rvalid` pulse.

Top module: `paged_reg_window`

## Requirements
- R1: While `rst_n` is low and after its release, the stored page is zero and `int_req` is low.
- R2: A write to outer offset 0x41C stores bits [22:0] of `cfg_wdata` as the page and completes in the same cycle. A read at 0x41C returns the page zero-extended to 32 bits in the same cycle.
- R3: The page keeps its value across any number of window reads and writes until 0x41C is written again.
- R4: A write to outer offsets 0x800 to 0x9FF raises `int_req` and `int_we` in that same cycle. `int_addr` is {page, `cfg_addr`[8:0]} and `int_wdata` is `cfg_wdata`. `cfg_ready` is high in that cycle.
- R5: A read from outer offsets 0x800 to 0x9FF raises `int_req` with `int_we` low and the same address as in R4, with `cfg_ready` low. `cfg_ready` stays low until `int_rvalid` arrives. In the cycle `int_rvalid` is high, `cfg_ready` is high and `cfg_rdata` equals `int_rdata`.
- R6: An outer access to any other offset raises no `int_req` and completes in its first cycle. A read returns zero. A write there leaves the page unchanged.
- R7: The page field spans the whole internal space above the window. Page 0x80D with window offset 0x018 forms internal address 0x00101A18, and the all-ones page 0x7FFFFF is stored and read back intact.
- R8: Each outer window read issues exactly one internal request. No new `int_req` is raised while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_req | input | 1 | Outer access request, held until ready |
| cfg_we | input | 1 | Outer access is a write |
| cfg_addr | input | 12 | Outer byte offset |
| cfg_wdata | input | 32 | Outer write data |
| cfg_ready | output | 1 | Outer access completes this cycle |
| cfg_rdata | output | 32 | Outer read data, valid with `cfg_ready` |
| int_req | output | 1 | Internal access request, one cycle |
| int_we | output | 1 | Internal access is a write |
| int_addr | output | 32 | Internal byte address |
| int_wdata | output | 32 | Internal write data |
| int_rvalid | input | 1 | Internal read data valid, one-cycle pulse |
| int_rdata | input | 32 | Internal read data |

## Verification
The table of vectors steps through several patterns:
- a low page with offsets at both ends of the window, which tells apart offset bits that are cut or shifted;
- the high page 0x80D, which shows whether upper page bits reach `int_addr`;
- an all-ones page write, which shows the field width and the zero extension on readback;
- a read at the same offset under a different page, which shows that the page, not the offset alone, selects the word.

Readbacks after window traffic separate a page that holds from one that window accesses disturb. The read stall length and the count of internal requests separate a single-shot read from a repeated or early-completing one. Directed tests write and read offsets just outside the window and beside the page register, to show that nothing leaks to the internal side or into the page.

// File: rtl/prw_pkg.sv
package prw_pkg;

   // Which outer region an offset falls into
   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_PAGE = 2'd1,
      HIT_WIN  = 2'd2
   } prw_hit_e;

   // Window read progress
   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_WAIT = 2'd1,
      RD_HOLD = 2'd2
   } prw_rd_e;

endpackage

// File: rtl/prw_decode.sv
module prw_decode
   import prw_pkg::*;
#(
   parameter int unsigned OUT_AW   = 12,
   parameter int unsigned PAGE_OFS = 'h41C,
   parameter int unsigned WIN_BASE = 'h800,
   parameter int unsigned WIN_BITS = 9
) (
   input  logic [OUT_AW-1:0] addr,
   output prw_hit_e          hit
);
   localparam int unsigned     TAG_W  = OUT_AW - WIN_BITS;
   localparam logic [OUT_AW-1:0] PAGE_A = OUT_AW'(PAGE_OFS);
   localparam logic [OUT_AW-1:0] WIN_A  = OUT_AW'(WIN_BASE);
   localparam logic [TAG_W-1:0]  WIN_TAG = WIN_A[OUT_AW-1:WIN_BITS];

   logic [TAG_W-1:0] tag;
   assign tag = addr[OUT_AW-1:WIN_BITS];

   // Page register is checked first; elaboration keeps it out of the window
   always_comb begin
      if (addr == PAGE_A) begin
         hit = HIT_PAGE;
      end else if (tag == WIN_TAG) begin
         hit = HIT_WIN;
      end else begin
         hit = HIT_NONE;
      end
   end

endmodule

// File: rtl/prw_page_reg.sv
module prw_page_reg #(
   parameter int unsigned PAGE_W = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PAGE_W-1:0] wr_page,
   output logic [PAGE_W-1:0] page
);
   logic [PAGE_W-1:0] page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (wr_en) begin
         page_q <= wr_page;
      end
   end

   assign page = page_q;

endmodule

// File: rtl/prw_read_track.sv
module prw_read_track
   import prw_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter bit          READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rvalid,
   input  logic [DATA_W-1:0] rdata_in,
   output logic              idle,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   prw_rd_e state_q;
   prw_rd_e state_d;

   generate
      if (READ_REG) begin : g_reg
         // Returned data is captured and presented one cycle later
         logic [DATA_W-1:0] hold_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= '0;
            end else if (state_q == RD_WAIT && rvalid) begin
               hold_q <= rdata_in;
            end
         end

         always_comb begin
            state_d = state_q;
            case (state_q)
               RD_IDLE: if (start)  state_d = RD_WAIT;
               RD_WAIT: if (rvalid) state_d = RD_HOLD;
               default:             state_d = RD_IDLE;
            endcase
         end

         assign done  = (state_q == RD_HOLD);
         assign rdata = hold_q;
      end else begin : g_pass
         // Returned data goes straight to the outer side
         always_comb begin
            state_d = state_q;
            case (state_q)
               RD_IDLE: if (start)  state_d = RD_WAIT;
               RD_WAIT: if (rvalid) state_d = RD_IDLE;
               default:             state_d = RD_IDLE;
            endcase
         end

         assign done  = (state_q == RD_WAIT) && rvalid;
         assign rdata = rdata_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RD_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign idle = (state_q == RD_IDLE);

endmodule

// File: rtl/paged_reg_window.sv
module paged_reg_window
   import prw_pkg::*;
#(
   parameter int unsigned OUT_AW   = 12,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned WIN_BITS = 9,
   parameter int unsigned PAGE_OFS = 'h41C,
   parameter int unsigned WIN_BASE = 'h800,
   parameter bit          READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_req,
   input  logic              cfg_we,
   input  logic [OUT_AW-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              cfg_ready,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              int_req,
   output logic              int_we,
   output logic [ADDR_W-1:0] int_addr,
   output logic [DATA_W-1:0] int_wdata,
   input  logic              int_rvalid,
   input  logic [DATA_W-1:0] int_rdata
);
   localparam int unsigned PAGE_W   = ADDR_W - WIN_BITS;
   localparam int unsigned WIN_SPAN = 1 << WIN_BITS;

   // Elaboration-time parameter checks
   generate
      if (WIN_BITS >= OUT_AW) begin : g_chk_win
         $error("window must be smaller than the outer space");
      end
      if (PAGE_W > DATA_W) begin : g_chk_rb
         $error("page must fit in one data word for readback");
      end
      if (PAGE_W < 12) begin : g_chk_reach
         $error("page field too narrow for the internal space");
      end
      if ((WIN_BASE % WIN_SPAN) != 0) begin : g_chk_align
         $error("window base must be aligned to its size");
      end
      if (PAGE_OFS >= WIN_BASE && PAGE_OFS < WIN_BASE + WIN_SPAN) begin : g_chk_ovl
         $error("page register must lie outside the window");
      end
   endgenerate

   prw_hit_e          hit;
   logic [PAGE_W-1:0] page_q;
   logic              page_wr;
   logic              win_acc;
   logic              trk_idle;
   logic              trk_done;
   logic [DATA_W-1:0] trk_rdata;

   prw_decode #(
      .OUT_AW  (OUT_AW),
      .PAGE_OFS(PAGE_OFS),
      .WIN_BASE(WIN_BASE),
      .WIN_BITS(WIN_BITS)
   ) u_decode (
      .addr(cfg_addr),
      .hit (hit)
   );

   assign page_wr = cfg_req && cfg_we && (hit == HIT_PAGE);

   prw_page_reg #(
      .PAGE_W(PAGE_W)
   ) u_page (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (page_wr),
      .wr_page(cfg_wdata[PAGE_W-1:0]),
      .page   (page_q)
   );

   // Only an idle tracker may launch an internal access
   assign win_acc = cfg_req && (hit == HIT_WIN) && trk_idle;

   prw_read_track #(
      .DATA_W  (DATA_W),
      .READ_REG(READ_REG)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (win_acc && !cfg_we),
      .rvalid  (int_rvalid),
      .rdata_in(int_rdata),
      .idle    (trk_idle),
      .done    (trk_done),
      .rdata   (trk_rdata)
   );

   assign int_req   = win_acc;
   assign int_we    = cfg_we;
   assign int_addr  = {page_q, cfg_addr[WIN_BITS-1:0]};
   assign int_wdata = cfg_wdata;

   always_comb begin
      cfg_ready = 1'b0;
      cfg_rdata = '0;
      if (cfg_req) begin
         case (hit)
            HIT_PAGE: begin
               cfg_ready = 1'b1;
               if (!cfg_we) cfg_rdata = DATA_W'(page_q);
            end
            HIT_WIN: begin
               if (cfg_we) begin
                  cfg_ready = trk_idle;
               end else begin
                  cfg_ready = trk_done;
                  if (trk_done) cfg_rdata = trk_rdata;
               end
            end
            default: cfg_ready = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/prw_window_chk.sv
module prw_window_chk #(
   parameter int unsigned OUT_AW   = 12,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned WIN_BITS = 9,
   parameter int unsigned PAGE_OFS = 'h41C,
   parameter int unsigned WIN_BASE = 'h800,
   parameter bit          READ_REG = 1'b0
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cfg_req,
   input logic                       cfg_we,
   input logic [OUT_AW-1:0]          cfg_addr,
   input logic                       cfg_ready,
   input logic                       int_req,
   input logic                       int_we,
   input logic [ADDR_W-1:0]          int_addr,
   input logic                       int_rvalid,
   input logic [ADDR_W-WIN_BITS-1:0] page
);
   localparam logic [OUT_AW-1:0] PG_A  = OUT_AW'(PAGE_OFS);
   localparam logic [OUT_AW-1:0] WN_A  = OUT_AW'(WIN_BASE);

   logic in_win;
   logic pg_write;
   assign in_win   = (cfg_addr[OUT_AW-1:WIN_BITS] == WN_A[OUT_AW-1:WIN_BITS]);
   assign pg_write = cfg_req && cfg_we && (cfg_addr == PG_A);

   AST_NO_STRAY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> (cfg_req && in_win));  // R6

   AST_WIN_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> (int_addr[WIN_BITS-1:0] == cfg_addr[WIN_BITS-1:0]));  // R4

   AST_WIN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> (int_addr[ADDR_W-1:WIN_BITS] == page));  // R4

   AST_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req && !int_we) |-> !cfg_ready);  // R5

   AST_READ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req && !int_we) |=> !int_req);  // R8

   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pg_write) |-> $stable(page));  // R3

   generate
      if (!READ_REG) begin : g_pass_chk
         AST_RVALID_READY: assert property (@(posedge clk) disable iff (!rst_n)
            int_rvalid |-> cfg_ready);  // R5
      end
   endgenerate

endmodule

bind paged_reg_window prw_window_chk #(
   .OUT_AW  (OUT_AW),
   .ADDR_W  (ADDR_W),
   .WIN_BITS(WIN_BITS),
   .PAGE_OFS(PAGE_OFS),
   .WIN_BASE(WIN_BASE),
   .READ_REG(READ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_req   (cfg_req),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .cfg_ready (cfg_ready),
   .int_req   (int_req),
   .int_we    (int_we),
   .int_addr  (int_addr),
   .int_rvalid(int_rvalid),
   .page      (page_q)
);

// File: tb/paged_reg_window_test.sv
module paged_reg_window_test;
   localparam int RD_LAT = 3;
   localparam int NV     = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_req = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_ready;
   logic [31:0] cfg_rdata;
   logic        int_req;
   logic        int_we;
   logic [31:0] int_addr;
   logic [31:0] int_wdata;
   logic        int_rvalid = 1'b0;
   logic [31:0] int_rdata = '0;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   paged_reg_window uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_ready(cfg_ready), .cfg_rdata(cfg_rdata),
      .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
      .int_rvalid(int_rvalid), .int_rdata(int_rdata)
   );

   // Internal register space model
   logic [31:0] mem [logic [31:0]];
   int          req_cnt = 0;
   logic [31:0] seen_addr = '0;
   logic        seen_we = 1'b0;
   logic [31:0] seen_wdata = '0;
   int          rd_wait = 0;
   logic [31:0] rd_addr = '0;

   function automatic logic [31:0] peek(input logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return ~a;
   endfunction

   always @(posedge clk) begin
      int_rvalid <= 1'b0;
      if (rst_n && int_req) begin
         req_cnt    = req_cnt + 1;
         seen_addr  = int_addr;
         seen_we    = int_we;
         seen_wdata = int_wdata;
         if (int_we) begin
            mem[int_addr] = int_wdata;
         end else begin
            rd_wait <= RD_LAT;
            rd_addr <= int_addr;
         end
      end else if (rd_wait > 1) begin
         rd_wait <= rd_wait - 1;
      end else if (rd_wait == 1) begin
         rd_wait    <= 0;
         int_rvalid <= 1'b1;
         int_rdata  <= peek(rd_addr);
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // One outer access; called at a falling edge
   task automatic access(input logic we, input logic [11:0] addr, input logic [31:0] wd,
                         output logic [31:0] rd, output int stalls, output int nreq);
      int base;
      base      = req_cnt;
      cfg_req   = 1'b1;
      cfg_we    = we;
      cfg_addr  = addr;
      cfg_wdata = wd;
      stalls    = 0;
      #1;
      while (!cfg_ready && stalls < 64) begin
         @(negedge clk);
         #1;
         stalls++;
      end
      rd = cfg_rdata;
      @(posedge clk);
      @(negedge clk);
      cfg_req = 1'b0;
      cfg_we  = 1'b0;
      nreq    = req_cnt - base;
   endtask

   // {op, outer offset, write data, expected}; op 0 page write, 1 page read,
   // 2 window write (expected = internal address), 3 window read
   localparam logic [77:0] VEC [NV] = '{
      {2'd0, 12'h41C, 32'h0000080D, 32'h00000000},
      {2'd1, 12'h41C, 32'h00000000, 32'h0000080D},
      {2'd2, 12'h818, 32'hA5A50001, 32'h00101A18},
      {2'd3, 12'h818, 32'h00000000, 32'hA5A50001},
      {2'd1, 12'h41C, 32'h00000000, 32'h0000080D},
      {2'd0, 12'h41C, 32'h00000003, 32'h00000000},
      {2'd2, 12'h800, 32'h11112222, 32'h00000600},
      {2'd2, 12'h9FC, 32'h33334444, 32'h000007FC},
      {2'd3, 12'h800, 32'h00000000, 32'h11112222},
      {2'd3, 12'h9FC, 32'h00000000, 32'h33334444},
      {2'd3, 12'h804, 32'h00000000, 32'hFFFFF9FB},
      {2'd0, 12'h41C, 32'h00000000, 32'h00000000},
      {2'd3, 12'h818, 32'h00000000, 32'hFFFFFFE7},
      {2'd0, 12'h41C, 32'hFFFFFFFF, 32'h00000000},
      {2'd1, 12'h41C, 32'h00000000, 32'h007FFFFF},
      {2'd2, 12'h9FC, 32'h00000005, 32'hFFFFFFFC},
      {2'd0, 12'h41C, 32'h0000080D, 32'h00000000},
      {2'd3, 12'h818, 32'h00000000, 32'hA5A50001}
   };

   initial begin
      logic [31:0] rd;
      int          st;
      int          nq;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(int_req == 1'b0, "R1 int_req low in reset", {31'd0, int_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      access(1'b0, 12'h41C, 32'h0, rd, st, nq);
      chk(rd == 32'h0, "R1 page zero after reset", rd, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [11:0] ad;
         logic [31:0] dt;
         logic [31:0] ex;
         op = VEC[i][77:76];
         ad = VEC[i][75:64];
         dt = VEC[i][63:32];
         ex = VEC[i][31:0];
         access(op[0] == 1'b0 && op != 2'd3 ? 1'b1 : (op == 2'd2), ad, dt, rd, st, nq);
         case (op)
            2'd0: chk(st == 0 && nq == 0, "R2 page write same cycle", st, 0);
            2'd1: chk(rd == ex, "R2 R3 R7 page readback", rd, ex);
            2'd2: begin
               chk(st == 0 && nq == 1, "R4 window write posted", st, 0);
               chk(seen_addr == ex, "R4 R7 internal write address", seen_addr, ex);
               chk(seen_we == 1'b1 && seen_wdata == dt, "R4 internal write data", seen_wdata, dt);
            end
            default: begin
               chk(rd == ex, "R5 window read data", rd, ex);
               chk(st == RD_LAT + 1, "R5 read stall length", st, RD_LAT + 1);
               chk(nq == 1 && seen_we == 1'b0, "R8 one internal read", nq, 1);
            end
         endcase
      end

      // R6: unmapped writes do not forward and leave page alone
      access(1'b1, 12'h420, 32'h00000123, rd, st, nq);
      chk(st == 0 && nq == 0, "R6 write beside page reg", nq, 0);
      access(1'b1, 12'h7FC, 32'h00000456, rd, st, nq);
      chk(st == 0 && nq == 0, "R6 write below window", nq, 0);
      access(1'b1, 12'hA00, 32'h00000789, rd, st, nq);
      chk(st == 0 && nq == 0, "R6 write above window", nq, 0);
      access(1'b0, 12'h41C, 32'h0, rd, st, nq);
      chk(rd == 32'h0000080D, "R6 page unchanged by unmapped writes", rd, 32'h0000080D);

      // R6: unmapped reads return zero
      access(1'b0, 12'h000, 32'h0, rd, st, nq);
      chk(rd == 32'h0 && nq == 0 && st == 0, "R6 read at offset 0", rd, 32'h0);
      access(1'b0, 12'hA00, 32'h0, rd, st, nq);
      chk(rd == 32'h0 && nq == 0 && st == 0, "R6 read above window", rd, 32'h0);
      access(1'b0, 12'h418, 32'h0, rd, st, nq);
      chk(rd == 32'h0 && nq == 0, "R6 read beside page reg", rd, 32'h0);

      // R5/R8: request and stall visible in the first cycle of a read
      cfg_req  = 1'b1;
      cfg_we   = 1'b0;
      cfg_addr = 12'h818;
      #1;
      chk(int_req && !int_we && !cfg_ready, "R5 read issue cycle", {30'd0, int_req, cfg_ready}, 32'd2);
      @(negedge clk);
      #1;
      chk(!int_req && !cfg_ready, "R8 no reissue while waiting", {30'd0, int_req, cfg_ready}, 32'd0);
      while (!cfg_ready) begin
         @(negedge clk);
         #1;
      end
      chk(cfg_rdata == 32'hA5A50001, "R5 returned data", cfg_rdata, 32'hA5A50001);
      @(posedge clk);
      @(negedge clk);
      cfg_req = 1'b0;

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #1_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule